// File: doc/BRIEF.md
# Frame Interrupt Entry Sequencer

This block sits beside the core of a small 8-bit processor with a 16-bit program counter and a 16-bit stack pointer. It produces a periodic frame request, holds the processor flag byte, and takes over a byte-wide memory port to carry out interrupt entry and return. The frame period is measured in instruction slots: every retired instruction counts one slot, and so does every clock the processor spends stopped in HALT.

The request is taken at an instruction boundary only when the mask bit is clear. While the mask bit is set, the request is held. Entry stacks the return address and the flag byte, leaves only the mask bit set in the flags, and loads the new program counter from a fixed two-byte vector. A return instruction pulls the flags and the address back off the stack. While a sequence runs, `stall_o` holds the instruction fetch. The core reports each retired instruction with `retire_i`, together with its kind: halt, return, clear-mask or set-mask.

Top module: `frint_seq`

## Requirements
- R1: After reset, `flags_o` is 0x10. The mask bit is bit 4, and a 1 in it disables the frame interrupt. After reset `stall_o`, `mem_req_o`, `pc_load_o`, `sp_we_o` and `frame_req_o` are all low.
- R2: `frame_req_o` rises once for every FRAME_INSNS slots. A slot is a retire accepted while not stalled, or one clock spent halted.
- R3: A frame request that arrives while the mask bit is set stays pending. It is taken at the first accepted retire after which the mask bit is clear. Entry starts on the next clock, and `frame_req_o` drops as entry starts.
- R4: Entry makes three write beats on consecutive clocks, starting from the stack pointer value S sampled at the boundary. The return PC high byte goes to S-1, the low byte to S-2, and the flag byte to S-3. `stall_o` is high throughout.
- R5: After the flag byte is written, `flags_o` becomes 0x10: every flag is clear except the mask bit.
- R6: After the write beats, entry reads VEC_ADDR and then VEC_ADDR+1 (0xff00 and 0xff01 by default). On the second read, `pc_load_o` pulses with `pc_o` = {high byte, low byte} and `sp_o` = S-3 with `sp_we_o`. Fetch resumes on the next clock.
- R7: A retired return instruction with stack pointer S reads the flags from S, the PC low byte from S+1 and the PC high byte from S+2. The restored flag byte appears on `flags_o` after the first read. On the third read, `pc_load_o` pulses with the restored PC and `sp_o` = S+3.
- R8: A retired clear-mask instruction clears the mask bit outside a handler and has no effect inside one. A retired set-mask instruction always sets it. "Inside a handler" means from entry until the return completes.
- R9: A retired HALT that does not itself take the interrupt stops the core: `stall_o` stays high with no memory beats. It leaves only through entry, which needs a pending request and a clear mask. With the mask set it never leaves.
- R10: An ALU flag write that comes with an accepted retire replaces every flag bit except bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| retire_i | input | 1 | One instruction completes this clock |
| halt_i | input | 1 | Retiring instruction is HALT |
| iret_i | input | 1 | Retiring instruction is interrupt return |
| cif_i | input | 1 | Retiring instruction clears the mask bit |
| sif_i | input | 1 | Retiring instruction sets the mask bit |
| pc_next_i | input | 16 | Address of the instruction after the retiring one |
| sp_i | input | 16 | Current stack pointer |
| alu_flags_we_i | input | 1 | ALU writes the flags with this retire |
| alu_flags_i | input | 8 | Flag value from the ALU |
| stall_o | output | 1 | Hold instruction fetch |
| mem_req_o | output | 1 | Memory beat this clock |
| mem_we_o | output | 1 | Beat is a write |
| mem_addr_o | output | 16 | Beat address |
| mem_wdata_o | output | 8 | Write data |
| mem_rdata_i | input | 8 | Read data, valid in the same clock as the beat |
| pc_load_o | output | 1 | Load `pc_o` into the program counter |
| pc_o | output | 16 | New program counter |
| sp_we_o | output | 1 | Load `sp_o` into the stack pointer |
| sp_o | output | 16 | New stack pointer |
| flags_o | output | 8 | Flag register |
| frame_req_o | output | 1 | Frame request pending |

## Verification
A wrong slot count appears on `frame_req_o` at the boundary where the request should have been raised. A lost pending request, or a mask bit in the wrong state, shows up as a missing or stray write beat on the clock after the deciding retire. A sequencing fault (beat order, address offset, wrong byte, or a late return to fetch) is visible in the same clock on the memory port, `pc_o` or `sp_o`. A flag fault is visible on `flags_o` one clock after the retire, beat or ALU write that caused it.

// File: rtl/frint_pkg.sv
package frint_pkg;
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned MASK_BIT = 4;
  localparam logic [DATA_W-1:0] MASK_ONLY = DATA_W'(1) << MASK_BIT;

  typedef enum logic [3:0] {
    ST_RUN,
    ST_HALT,
    ST_E_PCH,
    ST_E_PCL,
    ST_E_FLG,
    ST_E_VLO,
    ST_E_VHI,
    ST_R_FLG,
    ST_R_PCL,
    ST_R_PCH
  } seq_state_e;
endpackage

// File: rtl/frint_tick.sv
module frint_tick #(
  parameter int unsigned LIMIT = 133333
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adv_i,
  output logic tick_o
);
  localparam int unsigned CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          at_last;

  assign at_last = (cnt_q == LAST);
  assign tick_o  = adv_i && at_last;

  always_comb begin
    cnt_d = cnt_q;
    if (adv_i) begin
      if (at_last) cnt_d = '0;
      else         cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (adv_i) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/frint_flags.sv
module frint_flags
  import frint_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ret_ok_i,
  input  logic              cif_i,
  input  logic              sif_i,
  input  logic              alu_we_i,
  input  logic [DATA_W-1:0] alu_flags_i,
  input  logic              ent_clr_i,
  input  logic              rest_ld_i,
  input  logic [DATA_W-1:0] rest_data_i,
  input  logic              rest_done_i,
  output logic [DATA_W-1:0] flags_o,
  output logic              mask_next_o,
  output logic              in_hdl_o
);
  logic [DATA_W-1:0] flg_q, flg_d;
  logic              hdl_q, hdl_d;
  logic              flg_en, hdl_en;

  // mask value once the retiring instruction has taken effect
  always_comb begin
    if (sif_i)               mask_next_o = 1'b1;
    else if (cif_i && !hdl_q) mask_next_o = 1'b0;
    else                     mask_next_o = flg_q[MASK_BIT];
  end

  always_comb begin
    flg_d  = flg_q;
    flg_en = 1'b0;
    if (ent_clr_i) begin
      flg_d  = MASK_ONLY;
      flg_en = 1'b1;
    end else if (rest_ld_i) begin
      flg_d  = rest_data_i;
      flg_en = 1'b1;
    end else if (ret_ok_i) begin
      if (alu_we_i) flg_d = alu_flags_i;
      flg_d[MASK_BIT] = mask_next_o;
      flg_en = 1'b1;
    end
  end

  always_comb begin
    hdl_d  = hdl_q;
    hdl_en = ent_clr_i || rest_done_i;
    if (ent_clr_i)        hdl_d = 1'b1;
    else if (rest_done_i) hdl_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flg_q <= MASK_ONLY;
    else if (flg_en) flg_q <= flg_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hdl_q <= 1'b0;
    else if (hdl_en) hdl_q <= hdl_d;
  end

  assign flags_o  = flg_q;
  assign in_hdl_o = hdl_q;
endmodule

// File: rtl/frint_fsm.sv
module frint_fsm
  import frint_pkg::*;
#(
  parameter logic [ADDR_W-1:0] VEC_ADDR = 16'hff00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              retire_i,
  input  logic              halt_i,
  input  logic              iret_i,
  input  logic [ADDR_W-1:0] pc_next_i,
  input  logic [ADDR_W-1:0] sp_i,
  input  logic              mask_next_i,
  input  logic              mask_i,
  input  logic [DATA_W-1:0] flags_i,
  input  logic              tick_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              adv_o,
  output logic              ret_ok_o,
  output logic              stall_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              pc_load_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic              sp_we_o,
  output logic [ADDR_W-1:0] sp_o,
  output logic              ent_clr_o,
  output logic              rest_ld_o,
  output logic              rest_done_o,
  output logic              frame_req_o
);
  localparam logic [ADDR_W-1:0] OFS1 = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] OFS2 = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] OFS3 = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] VEC_HI = VEC_ADDR + OFS1;

  seq_state_e        st_q, st_d;
  logic [ADDR_W-1:0] ret_pc_q, ret_pc_d;
  logic [ADDR_W-1:0] base_q, base_d;
  logic [DATA_W-1:0] lo_q;
  logic              pend_q, pend_d, pend_after;
  logic              ctx_en, lo_en;

  assign ret_ok_o   = retire_i && (st_q == ST_RUN);
  assign adv_o      = ret_ok_o || (st_q == ST_HALT);
  assign pend_after = pend_q || tick_i;

  // next-state decision at the instruction boundary
  always_comb begin
    st_d     = st_q;
    pend_d   = pend_after;
    ret_pc_d = ret_pc_q;
    base_d   = base_q;
    ctx_en   = 1'b0;
    unique case (st_q)
      ST_RUN: begin
        if (ret_ok_o) begin
          if (iret_i) begin
            st_d   = ST_R_FLG;
            base_d = sp_i;
            ctx_en = 1'b1;
          end else if (pend_after && !mask_next_i) begin
            st_d     = ST_E_PCH;
            pend_d   = 1'b0;
            ret_pc_d = pc_next_i;
            base_d   = sp_i;
            ctx_en   = 1'b1;
          end else if (halt_i) begin
            st_d     = ST_HALT;
            ret_pc_d = pc_next_i;
            base_d   = sp_i;
            ctx_en   = 1'b1;
          end
        end
      end
      ST_HALT: begin
        if (pend_after && !mask_i) begin
          st_d   = ST_E_PCH;
          pend_d = 1'b0;
        end
      end
      ST_E_PCH: st_d = ST_E_PCL;
      ST_E_PCL: st_d = ST_E_FLG;
      ST_E_FLG: st_d = ST_E_VLO;
      ST_E_VLO: st_d = ST_E_VHI;
      ST_E_VHI: st_d = ST_RUN;
      ST_R_FLG: st_d = ST_R_PCL;
      ST_R_PCL: st_d = ST_R_PCH;
      ST_R_PCH: st_d = ST_RUN;
      default:  st_d = ST_RUN;
    endcase
  end

  // memory beat per state
  always_comb begin
    mem_req_o   = 1'b1;
    mem_we_o    = 1'b0;
    mem_addr_o  = base_q;
    mem_wdata_o = '0;
    unique case (st_q)
      ST_E_PCH: begin
        mem_we_o    = 1'b1;
        mem_addr_o  = base_q - OFS1;
        mem_wdata_o = ret_pc_q[ADDR_W-1:DATA_W];
      end
      ST_E_PCL: begin
        mem_we_o    = 1'b1;
        mem_addr_o  = base_q - OFS2;
        mem_wdata_o = ret_pc_q[DATA_W-1:0];
      end
      ST_E_FLG: begin
        mem_we_o    = 1'b1;
        mem_addr_o  = base_q - OFS3;
        mem_wdata_o = flags_i;
      end
      ST_E_VLO: mem_addr_o = VEC_ADDR;
      ST_E_VHI: mem_addr_o = VEC_HI;
      ST_R_FLG: mem_addr_o = base_q;
      ST_R_PCL: mem_addr_o = base_q + OFS1;
      ST_R_PCH: mem_addr_o = base_q + OFS2;
      default:  mem_req_o  = 1'b0;
    endcase
  end

  assign lo_en       = (st_q == ST_E_VLO) || (st_q == ST_R_PCL);
  assign stall_o     = (st_q != ST_RUN);
  assign pc_load_o   = (st_q == ST_E_VHI) || (st_q == ST_R_PCH);
  assign pc_o        = {mem_rdata_i, lo_q};
  assign sp_we_o     = pc_load_o;
  assign sp_o        = (st_q == ST_E_VHI) ? (base_q - OFS3) : (base_q + OFS3);
  assign ent_clr_o   = (st_q == ST_E_FLG);
  assign rest_ld_o   = (st_q == ST_R_FLG);
  assign rest_done_o = (st_q == ST_R_PCH);
  assign frame_req_o = pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_RUN;
      pend_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ret_pc_q <= '0;
      base_q   <= '0;
    end else if (ctx_en) begin
      ret_pc_q <= ret_pc_d;
      base_q   <= base_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     lo_q <= '0;
    else if (lo_en) lo_q <= mem_rdata_i;
  end
endmodule

// File: rtl/frint_seq.sv
module frint_seq
  import frint_pkg::*;
#(
  parameter int unsigned       FRAME_INSNS = 133333,
  parameter logic [ADDR_W-1:0] VEC_ADDR    = 16'hff00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              retire_i,
  input  logic              halt_i,
  input  logic              iret_i,
  input  logic              cif_i,
  input  logic              sif_i,
  input  logic [ADDR_W-1:0] pc_next_i,
  input  logic [ADDR_W-1:0] sp_i,
  input  logic              alu_flags_we_i,
  input  logic [DATA_W-1:0] alu_flags_i,
  output logic              stall_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              pc_load_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic              sp_we_o,
  output logic [ADDR_W-1:0] sp_o,
  output logic [DATA_W-1:0] flags_o,
  output logic              frame_req_o
);
  logic [1:0] rsync_q;
  logic       rst_sync_n;
  logic       adv, tick, ret_ok, mask_next, in_hdl;
  logic       ent_clr, rest_ld, rest_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_sync_n = rsync_q[1];

  frint_tick #(.LIMIT(FRAME_INSNS)) u_tick (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .adv_i  (adv),
    .tick_o (tick)
  );

  frint_flags u_flags (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .ret_ok_i    (ret_ok),
    .cif_i       (cif_i),
    .sif_i       (sif_i),
    .alu_we_i    (alu_flags_we_i),
    .alu_flags_i (alu_flags_i),
    .ent_clr_i   (ent_clr),
    .rest_ld_i   (rest_ld),
    .rest_data_i (mem_rdata_i),
    .rest_done_i (rest_done),
    .flags_o     (flags_o),
    .mask_next_o (mask_next),
    .in_hdl_o    (in_hdl)
  );

  frint_fsm #(.VEC_ADDR(VEC_ADDR)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .retire_i    (retire_i),
    .halt_i      (halt_i),
    .iret_i      (iret_i),
    .pc_next_i   (pc_next_i),
    .sp_i        (sp_i),
    .mask_next_i (mask_next),
    .mask_i      (flags_o[MASK_BIT]),
    .flags_i     (flags_o),
    .tick_i      (tick),
    .mem_rdata_i (mem_rdata_i),
    .adv_o       (adv),
    .ret_ok_o    (ret_ok),
    .stall_o     (stall_o),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .pc_load_o   (pc_load_o),
    .pc_o        (pc_o),
    .sp_we_o     (sp_we_o),
    .sp_o        (sp_o),
    .ent_clr_o   (ent_clr),
    .rest_ld_o   (rest_ld),
    .rest_done_o (rest_done),
    .frame_req_o (frame_req_o)
  );
endmodule

// File: rtl/frint_seq_chk.sv
module frint_seq_chk
  import frint_pkg::*;
#(
  parameter logic [ADDR_W-1:0] VEC_ADDR = 16'hff00
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              retire_i,
  input logic              iret_i,
  input logic              cif_i,
  input logic              sif_i,
  input logic              stall_o,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              pc_load_o,
  input logic [DATA_W-1:0] flags_o,
  input logic              frame_req_o,
  input logic              in_hdl
);
  // R4: every memory beat happens with fetch held
  a_r4_beat_stalled: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mem_req_o |-> stall_o);

  // R6: fetch resumes right after the program counter load
  a_r6_resume: assert property (@(posedge clk) disable iff (!rst_sync_n)
    pc_load_o |=> !stall_o);

  // R5: flags hold only the mask bit when the vector is read
  a_r5_flags_cleared: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mem_req_o && !mem_we_o && mem_addr_o == VEC_ADDR) |-> (flags_o == MASK_ONLY));

  // R3: a pending request with a clear mask is taken at the next boundary
  a_r3_pending_taken: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (retire_i && !stall_o && frame_req_o && !flags_o[MASK_BIT] && !sif_i && !iret_i)
      |=> (stall_o && mem_req_o && mem_we_o));

  // R8: clear-mask inside a handler leaves the mask set
  a_r8_cif_ignored: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (retire_i && !stall_o && cif_i && in_hdl && flags_o[MASK_BIT]) |=> flags_o[MASK_BIT]);

  // R9: halted with the mask set stays halted
  a_r9_halt_stuck: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (stall_o && !mem_req_o && flags_o[MASK_BIT]) |=> (stall_o && !mem_req_o));
endmodule

bind frint_seq frint_seq_chk #(.VEC_ADDR(VEC_ADDR)) u_chk (.*);

// File: tb/sim_frint_seq.sv
`timescale 1ns/1ps
module sim_frint_seq;
  localparam int unsigned N = 10;
  localparam logic [15:0] VEC = 16'hff00;
  localparam logic [7:0]  MONLY = 8'h10;
  localparam int KPLAIN = 0, KCLR = 1, KRFLG = 2, KEEND = 3, KREND = 4;

  typedef struct {
    bit          we;
    logic [15:0] addr;
    logic [7:0]  wd;
    int          kind;
    logic [15:0] pc;
    logic [15:0] sp;
    logic [7:0]  val;
  } beat_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic retire = 0, halt = 0, iret = 0, cif = 0, sif = 0, awe = 0;
  logic [7:0]  aflags = '0;
  logic [15:0] pcn = '0, spi = '0;
  logic stall, mreq, mwe, pcld, spwe, freq;
  logic [15:0] maddr, pco, spo;
  logic [7:0]  mwd, mrd, flg;
  logic [7:0]  tmem [256];

  int n_cmp = 0, n_bad = 0, cyc = 0;
  string tag = "R1";

  // reference model state
  beat_t       q[$];
  bit          m_halt = 0, m_pend = 0, m_hdl = 0;
  int          m_cnt = 0;
  logic [7:0]  m_f = MONLY;
  logic [15:0] m_sp = 16'hfff0, m_hold = '0, m_base = '0;

  always #4 clk = ~clk;

  assign mrd = tmem[maddr[7:0]];

  frint_seq #(.FRAME_INSNS(N), .VEC_ADDR(VEC)) u0 (
    .clk(clk), .rst_n(rst_n), .retire_i(retire), .halt_i(halt), .iret_i(iret),
    .cif_i(cif), .sif_i(sif), .pc_next_i(pcn), .sp_i(spi),
    .alu_flags_we_i(awe), .alu_flags_i(aflags), .stall_o(stall),
    .mem_req_o(mreq), .mem_we_o(mwe), .mem_addr_o(maddr), .mem_wdata_o(mwd),
    .mem_rdata_i(mrd), .pc_load_o(pcld), .pc_o(pco), .sp_we_o(spwe), .sp_o(spo),
    .flags_o(flg), .frame_req_o(freq)
  );

  function automatic beat_t mk(bit we, logic [15:0] a, logic [7:0] d, int k);
    beat_t b;
    b.we = we; b.addr = a; b.wd = d; b.kind = k;
    b.pc = '0; b.sp = '0; b.val = '0;
    return b;
  endfunction

  task automatic issue_entry(logic [15:0] rpc, logic [15:0] s, logic [7:0] f);
    beat_t b;
    q.push_back(mk(1, s - 16'd1, rpc[15:8], KPLAIN));
    q.push_back(mk(1, s - 16'd2, rpc[7:0], KPLAIN));
    q.push_back(mk(1, s - 16'd3, f, KCLR));
    q.push_back(mk(0, VEC, '0, KPLAIN));
    b = mk(0, VEC + 16'd1, '0, KEEND);
    b.pc = {tmem[8'(VEC + 16'd1)], tmem[VEC[7:0]]};
    b.sp = s - 16'd3;
    q.push_back(b);
  endtask

  task automatic issue_return(logic [15:0] s);
    beat_t b;
    b = mk(0, s, '0, KRFLG);
    b.val = tmem[s[7:0]];
    q.push_back(b);
    q.push_back(mk(0, s + 16'd1, '0, KPLAIN));
    b = mk(0, s + 16'd2, '0, KREND);
    b.pc = {tmem[8'(s + 16'd2)], tmem[8'(s + 16'd1)]};
    b.sp = s + 16'd3;
    q.push_back(b);
  endtask

  // model step on each rising edge, from the requirements
  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); m_halt = 0; m_pend = 0; m_hdl = 0; m_cnt = 0; m_f = MONLY;
    end else begin
      bit idle, adv, pa, mnext;
      beat_t b;
      idle = (q.size() == 0) && !m_halt;
      adv  = (idle && retire) || m_halt;
      pa   = m_pend;
      if (adv) begin
        if (m_cnt == N - 1) begin m_cnt = 0; pa = 1; end
        else m_cnt++;
      end
      if (q.size() > 0) begin
        b = q.pop_front();
        if (b.kind == KCLR)  begin m_f = MONLY; m_hdl = 1; end
        if (b.kind == KRFLG) m_f = b.val;
        if (b.kind == KREND) begin m_hdl = 0; m_sp = b.sp; end
        if (b.kind == KEEND) m_sp = b.sp;
      end else if (m_halt) begin
        if (pa && !m_f[4]) begin
          m_halt = 0; pa = 0;
          issue_entry(m_hold, m_base, m_f);
        end
      end else if (retire) begin
        mnext = sif ? 1'b1 : ((cif && !m_hdl) ? 1'b0 : m_f[4]);
        if (awe) m_f = aflags;
        m_f[4] = mnext;
        if (iret) issue_return(spi);
        else if (pa && !mnext) begin
          pa = 0;
          issue_entry(pcn, spi, m_f);
        end else if (halt) begin
          m_halt = 1; m_hold = pcn; m_base = spi;
        end
      end
      m_pend = pa;
    end
  end

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // compare every clock, away from the rising edge
  always @(negedge clk) begin
    cyc++;
    chk("stall_o (R9)", 32'(stall), 32'((q.size() > 0) || m_halt));
    chk("frame_req_o (R2 R3)", 32'(freq), 32'(m_pend));
    chk("flags_o (R5 R8 R10)", 32'(flg), 32'(m_f));
    if (q.size() > 0) begin
      chk("mem_req_o (R4)", 32'(mreq), 32'd1);
      chk("mem_we_o (R4)", 32'(mwe), 32'(q[0].we));
      chk("mem_addr_o (R4 R6 R7)", 32'(maddr), 32'(q[0].addr));
      if (q[0].we) chk("mem_wdata_o (R4)", 32'(mwd), 32'(q[0].wd));
      chk("pc_load_o (R6 R7)", 32'(pcld), 32'(q[0].kind == KEEND || q[0].kind == KREND));
      chk("sp_we_o (R6 R7)", 32'(spwe), 32'(q[0].kind == KEEND || q[0].kind == KREND));
      if (q[0].kind == KEEND || q[0].kind == KREND) begin
        chk("pc_o (R6 R7)", 32'(pco), 32'(q[0].pc));
        chk("sp_o (R6 R7)", 32'(spo), 32'(q[0].sp));
      end
      if (mreq && mwe) tmem[maddr[7:0]] = mwd;
    end else begin
      chk("mem_req_o idle", 32'(mreq), 32'd0);
      chk("pc_load_o idle", 32'(pcld), 32'd0);
      chk("sp_we_o idle", 32'(spwe), 32'd0);
    end
    if (cyc > 20000) begin
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=<20000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic insn(bit h, bit ir, bit c, bit s, bit aw, logic [7:0] af, logic [15:0] pc);
    while (q.size() > 0 || m_halt) @(negedge clk);
    retire = 1; halt = h; iret = ir; cif = c; sif = s; awe = aw; aflags = af;
    pcn = pc; spi = m_sp;
    @(negedge clk);
    retire = 0; halt = 0; iret = 0; cif = 0; sif = 0; awe = 0;
  endtask

  task automatic settle();
    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    foreach (tmem[i]) tmem[i] = 8'h00;
    tmem[8'h00] = 8'h34;
    tmem[8'h01] = 8'h12;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);

    tag = "R10";
    insn(0, 0, 0, 0, 1, 8'hff, 16'h0102);
    insn(0, 0, 0, 0, 1, 8'h25, 16'h0104);
    insn(0, 0, 0, 0, 1, 8'h00, 16'h0106);

    tag = "R2";
    for (int i = 0; i < 9; i++) insn(0, 0, 0, 0, 0, 8'h00, 16'(16'h0108 + 2 * i));

    tag = "R3";
    insn(0, 0, 0, 0, 0, 8'h00, 16'h0130);
    insn(0, 0, 1, 0, 1, 8'h81, 16'h0132);
    tag = "R4";
    settle();

    tag = "R8";
    insn(0, 0, 1, 0, 0, 8'h00, 16'h1236);
    insn(0, 0, 0, 0, 1, 8'h0f, 16'h1238);
    tag = "R7";
    insn(0, 1, 0, 0, 0, 8'h00, 16'h123a);
    settle();

    tag = "R9";
    insn(1, 0, 0, 0, 0, 8'h00, 16'h0200);
    settle();
    while (m_hdl) begin
      insn(0, 1, 0, 0, 0, 8'h00, 16'h1240);
      settle();
    end

    tag = "R8";
    insn(0, 0, 0, 1, 0, 8'h00, 16'h0300);
    tag = "R9";
    insn(1, 0, 0, 0, 0, 8'h00, 16'h0302);
    repeat (40) @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule